// File: doc/BRIEF.md
# Interrupt Request Acknowledge Sequencer

This block sits between a processor core and its external interrupt pins. It watches a level-sensitive maskable request, an edge-sensitive non-maskable request and a level-sensitive reset. It then hands the core an 8-bit vector, marked by a one-cycle valid strobe.

A maskable request is taken only while the core's interrupt-enable flag is set. It is confirmed once more just before the bus is used, so a request that has gone away by then is dropped. When confirmed, the block asks a bus controller for two interrupt-acknowledge cycles in a row. The vector is the low data byte seen when the second of those cycles completes.

A non-maskable request needs no bus traffic, because it always uses the fixed vector 2. After one is serviced, further non-maskable edges are held back until the core reports a return-from-interrupt. A single edge that arrives during that hold-off is remembered and serviced as soon as the hold-off ends.

Top module: `irq_ack_sequencer`

## Requirements
- R1: With `ifEnable` low, a high `intrReq` starts no acknowledge cycle and produces no vector.
- R2: A confirmed maskable request runs exactly two acknowledge cycles back to back. `ackReq` stays high through both and each cycle ends on an `ackDone` pulse. `ackSecond` is low during the first cycle and high during the second.
- R3: The vector equals `dataLow` as sampled with the `ackDone` that ends the second cycle, and `vecValid` is high for the following cycle. Data present when the first cycle ends is not used.
- R4: A rising edge on `nmiReq` yields vector 2 with no acknowledge cycle. `vecValid` is high in the cycle after the second clock edge that samples `nmiReq` high following a low sample.
- R5: After a non-maskable vector is issued, further `nmiReq` edges produce no vector until `iretDone` is pulsed. Holding `nmiReq` high never retriggers.
- R6: Any number of `nmiReq` edges during the hold-off collapse into one pending request. That request yields exactly one vector 2 after `iretDone`.
- R7: When a non-maskable request and a maskable request are both pending at the same decision point, vector 2 is issued first. The maskable sequence follows.
- R8: A maskable request that is sampled once and then drops before the first acknowledge cycle begins is cancelled, with no acknowledge cycle and no vector.
- R9: `cpuReset` aborts any acknowledge sequence, clears the hold-off and any pending request, and drives `ackReq` and `vecValid` low. An `nmiReq` held high through reset is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cpuReset | input | 1 | Level-sensitive synchronous reset, overrides all inputs |
| intrReq | input | 1 | Maskable request, level-sensitive |
| nmiReq | input | 1 | Non-maskable request, rising-edge sensitive |
| ifEnable | input | 1 | Interrupt-enable flag from the core |
| iretDone | input | 1 | One-cycle strobe: return-from-interrupt completed |
| ackReq | output | 1 | Request to the bus controller for an acknowledge cycle |
| ackSecond | output | 1 | High when the requested acknowledge cycle is the second one |
| ackDone | input | 1 | One-cycle pulse from the bus controller ending the current acknowledge cycle |
| dataLow | input | 8 | Low byte of the data bus |
| vecOut | output | 8 | Interrupt vector for the core |
| vecValid | output | 1 | One-cycle strobe qualifying `vecOut` |

## Verification
The maskable path is tested four ways: a held request with the flag set, a held request with the flag clear, a one-cycle blip that must be cancelled, and a request cut off by reset partway through the acknowledge pair. Together these separate masking, late confirmation and abort.

The first acknowledge cycle returns a decoy byte, so a vector taken at the wrong cycle is caught. Non-maskable stimulus includes a lone edge (checked for exact latency), repeated edges during hold-off (checked for collapse to one), an edge raced against a maskable request (checked for issue order), and a level held across reset (checked to be no edge at all).

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_ACK1 = 2'd2,
    ST_ACK2 = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadNmi;
    logic loadBus;
  } vecStrobe_t;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       cpuReset,
  input  logic       intrReq,
  input  logic       nmiReq,
  input  logic       ifEnable,
  input  logic       iretDone,
  input  logic       ackDone,
  output logic       ackReq,
  output logic       ackSecond,
  output vecStrobe_t strobe
);

  seqState_t state, stateNext;
  logic nmiPrev;
  logic nmiPending;
  logic nmiLock;
  logic nmiEdge;
  logic nmiBlocked;
  logic takeNmi;

  assign nmiEdge    = nmiReq & ~nmiPrev;
  // lock release is visible in the same cycle as the return strobe
  assign nmiBlocked = nmiLock & ~iretDone;
  assign takeNmi    = (state == ST_IDLE) & nmiPending & ~nmiBlocked;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (!takeNmi && intrReq && ifEnable) stateNext = ST_ARM;
      ST_ARM:  stateNext = intrReq ? ST_ACK1 : ST_IDLE;
      ST_ACK1: if (ackDone) stateNext = ST_ACK2;
      ST_ACK2: if (ackDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cpuReset) begin
      state      <= ST_IDLE;
      nmiPrev    <= nmiReq;  // a level held through reset is no edge
      nmiPending <= 1'b0;
      nmiLock    <= 1'b0;
    end else begin
      state   <= stateNext;
      nmiPrev <= nmiReq;
      if (takeNmi)      nmiPending <= nmiEdge;
      else if (nmiEdge) nmiPending <= 1'b1;
      if (takeNmi)       nmiLock <= 1'b1;
      else if (iretDone) nmiLock <= 1'b0;
    end
  end

  assign ackReq         = (state == ST_ACK1) | (state == ST_ACK2);
  assign ackSecond      = (state == ST_ACK2);
  assign strobe.loadNmi = takeNmi;
  assign strobe.loadBus = (state == ST_ACK2) & ackDone;

  AST_MASKED_STAYS_IDLE: assert property (@(posedge clk) disable iff (cpuReset)
    (state == ST_IDLE && !ifEnable && !nmiPending) |=> (state == ST_IDLE)); // R1

  AST_SECOND_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (cpuReset)
    $rose(ackSecond) |-> $past(ackReq && !ackSecond && ackDone)); // R2

  AST_NO_NMI_WHILE_LOCKED: assert property (@(posedge clk) disable iff (cpuReset)
    strobe.loadNmi |-> !(nmiLock && !iretDone)); // R5

  AST_NMI_BEFORE_INTR: assert property (@(posedge clk) disable iff (cpuReset)
    (state == ST_IDLE && nmiPending && !nmiBlocked) |=> (state == ST_IDLE)); // R7

  AST_CANCEL_NO_ACK: assert property (@(posedge clk) disable iff (cpuReset)
    (state == ST_ARM && !intrReq) |=> !ackReq); // R8

endmodule

// File: rtl/irq_seq_datapath.sv
module irq_seq_datapath
  import irq_seq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             cpuReset,
  input  vecStrobe_t       strobe,
  input  logic [VEC_W-1:0] dataLow,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);

  localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

  always_ff @(posedge clk) begin
    if (cpuReset) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= strobe.loadNmi | strobe.loadBus;
      if (strobe.loadNmi)      vecOut <= NMI_CODE;
      else if (strobe.loadBus) vecOut <= dataLow;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (cpuReset)
    !(strobe.loadNmi && strobe.loadBus)); // R7

  AST_NMI_CODE: assert property (@(posedge clk) disable iff (cpuReset)
    strobe.loadNmi |=> (vecValid && vecOut == NMI_CODE)); // R4

  AST_BUS_CAPTURE: assert property (@(posedge clk) disable iff (cpuReset)
    strobe.loadBus |=> (vecValid && vecOut == $past(dataLow))); // R3

endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
  import irq_seq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             cpuReset,
  input  logic             intrReq,
  input  logic             nmiReq,
  input  logic             ifEnable,
  input  logic             iretDone,
  output logic             ackReq,
  output logic             ackSecond,
  input  logic             ackDone,
  input  logic [VEC_W-1:0] dataLow,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);

  vecStrobe_t strobe;

  irq_seq_ctrl u_ctrl (
    .clk       (clk),
    .cpuReset  (cpuReset),
    .intrReq   (intrReq),
    .nmiReq    (nmiReq),
    .ifEnable  (ifEnable),
    .iretDone  (iretDone),
    .ackDone   (ackDone),
    .ackReq    (ackReq),
    .ackSecond (ackSecond),
    .strobe    (strobe)
  );

  irq_seq_datapath #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_dp (
    .clk      (clk),
    .cpuReset (cpuReset),
    .strobe   (strobe),
    .dataLow  (dataLow),
    .vecOut   (vecOut),
    .vecValid (vecValid)
  );

endmodule

// File: tb/test_irq_ack_sequencer.sv
module test_irq_ack_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       cpuReset = 1'b1;
  logic       intrReq = 1'b0;
  logic       nmiReq = 1'b0;
  logic       ifEnable = 1'b0;
  logic       iretDone = 1'b0;
  logic       ackDone = 1'b0;
  logic [7:0] dataLow = 8'hEE;
  logic       ackReq, ackSecond, vecValid;
  logic [7:0] vecOut;

  irq_ack_sequencer i_irq_ack_sequencer (
    .clk(clk), .cpuReset(cpuReset), .intrReq(intrReq), .nmiReq(nmiReq),
    .ifEnable(ifEnable), .iretDone(iretDone), .ackReq(ackReq),
    .ackSecond(ackSecond), .ackDone(ackDone), .dataLow(dataLow),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int vecSeen = 0;
  int ackFirstCnt = 0;
  int ackSecondCnt = 0;
  int ackCycles = 0;
  int lat = 0;
  logic [7:0] busVec = 8'h00;
  logic [7:0] expQ[$];
  string      tagQ[$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expectVec(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // bus controller model: ends each acknowledge cycle after a short latency
  always @(negedge clk) begin
    if (ackReq && !cpuReset) ackCycles++;
    if (cpuReset || !ackReq || ackDone) begin
      ackDone = 1'b0;
      dataLow = 8'hEE;
      lat = 0;
    end else if (lat == 2) begin
      ackDone = 1'b1;
      dataLow = ackSecond ? busVec : 8'hEE;
      if (ackSecond) ackSecondCnt++;
      else ackFirstCnt++;
    end else begin
      lat++;
    end
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!cpuReset && vecValid) begin
      vecSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R1/R5/R8 unexpected vector", int'(vecOut), -1);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(vecOut == e, t, int'(vecOut), int'(e));
      end
    end
  end

  initial begin
    tick(WATCHDOG);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int snapV, snapA, guard;
    // reset state, R9
    tick(3);
    check(ackReq == 1'b0, "R9 reset ackReq", int'(ackReq), 0);
    check(vecValid == 1'b0, "R9 reset vecValid", int'(vecValid), 0);
    cpuReset = 1'b0;
    tick(2);

    // maskable with flag set, R2 and R3
    busVec = 8'h41;
    expectVec(8'h41, "R3 maskable vector");
    ifEnable = 1'b1;
    intrReq = 1'b1;
    guard = 0;
    while (!ackReq && guard < 50) begin tick(1); guard++; end
    intrReq = 1'b0;
    tick(20);
    check(ackFirstCnt == 1, "R2 first ack count", ackFirstCnt, 1);
    check(ackSecondCnt == 1, "R2 second ack count", ackSecondCnt, 1);
    check(vecSeen == 1, "R3 vector count", vecSeen, 1);

    // masked, R1
    ifEnable = 1'b0;
    snapA = ackCycles;
    intrReq = 1'b1;
    tick(12);
    check(ackCycles == snapA, "R1 masked no ack", ackCycles, snapA);
    intrReq = 1'b0;
    ifEnable = 1'b1;
    tick(2);

    // one-cycle blip cancelled, R8
    snapA = ackCycles;
    snapV = vecSeen;
    intrReq = 1'b1;
    tick(1);
    intrReq = 1'b0;
    tick(12);
    check(ackCycles == snapA, "R8 cancel no ack", ackCycles, snapA);
    check(vecSeen == snapV, "R8 cancel no vector", vecSeen, snapV);

    // lone NMI edge, exact latency and no bus traffic, R4
    snapA = ackCycles;
    expectVec(8'd2, "R4 nmi vector");
    nmiReq = 1'b1;
    tick(1);
    check(vecValid == 1'b0, "R4 not yet valid", int'(vecValid), 0);
    tick(1);
    check(vecValid == 1'b1, "R4 valid latency", int'(vecValid), 1);
    check(vecOut == 8'd2, "R4 vector value", int'(vecOut), 2);
    tick(8);
    check(ackCycles == snapA, "R4 no ack cycles", ackCycles, snapA);

    // lockout, held level and repeated edges, R5
    snapV = vecSeen;
    nmiReq = 1'b0; tick(1);
    nmiReq = 1'b1; tick(1);
    nmiReq = 1'b0; tick(1);
    nmiReq = 1'b1; tick(10);
    check(vecSeen == snapV, "R5 locked no vector", vecSeen, snapV);

    // collapsed pending edge served once after return, R6
    expectVec(8'd2, "R6 deferred nmi");
    iretDone = 1'b1; tick(1);
    iretDone = 1'b0; tick(10);
    check(vecSeen == snapV + 1, "R6 exactly one vector", vecSeen, snapV + 1);

    // NMI and maskable both pending at the same decision, R7
    nmiReq = 1'b0; tick(1);
    nmiReq = 1'b1; tick(1);
    ifEnable = 1'b0;
    intrReq = 1'b1;
    tick(3);
    snapV = vecSeen;
    busVec = 8'h5A;
    expectVec(8'd2, "R7 nmi first");
    expectVec(8'h5A, "R7 maskable second");
    ifEnable = 1'b1;
    iretDone = 1'b1;
    tick(1);
    iretDone = 1'b0;
    guard = 0;
    while (!ackReq && guard < 50) begin tick(1); guard++; end
    intrReq = 1'b0;
    tick(20);
    check(vecSeen == snapV + 2, "R7 both vectors", vecSeen, snapV + 2);

    // reset aborts a sequence and clears lock, NMI held through reset, R9
    iretDone = 1'b1; tick(1);
    iretDone = 1'b0;
    nmiReq = 1'b0;
    busVec = 8'h77;
    intrReq = 1'b1;
    guard = 0;
    while (!ackReq && guard < 50) begin tick(1); guard++; end
    intrReq = 1'b0;
    nmiReq = 1'b1;
    cpuReset = 1'b1;
    tick(3);
    check(ackReq == 1'b0, "R9 abort ackReq", int'(ackReq), 0);
    check(vecValid == 1'b0, "R9 abort vecValid", int'(vecValid), 0);
    snapV = vecSeen;
    snapA = ackCycles;
    cpuReset = 1'b0;
    tick(12);
    check(vecSeen == snapV, "R9 no vector after reset", vecSeen, snapV);
    check(ackCycles == snapA, "R9 no ack after reset", ackCycles, snapA);
    nmiReq = 1'b0; tick(1);
    expectVec(8'd2, "R9 lock cleared by reset");
    nmiReq = 1'b1;
    tick(6);
    check(vecSeen == snapV + 1, "R9 nmi after reset", vecSeen, snapV + 1);

    tick(4);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule